// File: doc/BRIEF.md
# Vector Length Configuration Registers

This block keeps four small pieces of state that a vector unit needs: the largest vector length allowed, the vector length in force now, and two element offsets, one for sources and one for destinations. Software reaches them through three register addresses on a simple write port (enable, address, data) and a combinational read port. One address holds the largest length, one holds the current length, and the third packs all four values into one word.

Each write is clamped against the other stored values, so the state always stays consistent: the largest length stays between 1 and the configured ceiling, the current length never exceeds the largest length, and each offset stays below the current length. A packed write applies its fields in dependency order: the largest length first, then the current length against it, then the offsets against the new current length. A write of zero to either length register is refused and reported on a one-cycle flag.

Top module: `vec_len_cfg`

## Requirements
- R1: After reset the largest length and the current length are both 1 and both offsets are 0, so a read of the packed address returns 0.
- R2: A nonzero write to the largest-length address (default 0x0C0) stores min(value, MAX_LEN), with MAX_LEN defaulting to 64.
- R3: A nonzero write to the current-length address (default 0x0C1) stores min(largest length, value).
- R4: A read of the packed address (default 0x0C2) returns largest length minus 1 in bits 5:0, current length minus 1 in bits 11:6, source offset in bits 17:12, destination offset in bits 23:18 and zero above.
- R5: A write to the packed address sets the largest length to bits 5:0 plus 1, then the current length to min(new largest length, bits 11:6 plus 1).
- R6: A packed write sets the source offset to min(bits 17:12, new current length minus 1) and the destination offset to min(bits 23:18, new current length minus 1).
- R7: Reads of the largest-length and current-length addresses return the plain length, not the length minus 1.
- R8: A write of zero to the largest-length or current-length address leaves all four values unchanged and drives illegal_o high for exactly the one cycle that follows the write edge.
- R9: A write that lowers the largest length also lowers the current length to at most the new largest length, and any write of the current length lowers each offset to at most the new current length minus 1.
- R10: Writes with wr_en_i low or to any other address change nothing, and reads of any other address return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 12 | Write address |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 12 | Read address |
| rd_data_o | output | 32 | Read data, combinational |
| illegal_o | output | 1 | Pulses one cycle after a refused zero write |

## Verification
The hardest situation to reach from the ports is the chained clamp, where one packed write shrinks the largest length below the requested current length and that smaller current length then cuts both requested offsets. Random packed words rarely make all three fields collide at once, so directed packed writes with a small largest-length field and large offset fields are mixed into the random stream, together with largest-length writes that shrink under a long current length and nonzero offsets.

// File: rtl/vlcfg_pkg.sv
package vlcfg_pkg;
  typedef enum logic [1:0] {
    WK_NONE = 2'd0,
    WK_MVL  = 2'd1,
    WK_VL   = 2'd2,
    WK_PACK = 2'd3
  } wr_kind_e;
endpackage

// File: rtl/vlcfg_clamp.sv
module vlcfg_clamp #(
  parameter int IN_W  = 32,
  parameter int OUT_W = 7
) (
  input  logic [IN_W-1:0]  val_i,
  input  logic [OUT_W-1:0] lim_i,
  output logic [OUT_W-1:0] res_o
);
  always_comb begin
    if (val_i > IN_W'(lim_i)) res_o = lim_i;
    else                      res_o = val_i[OUT_W-1:0];
  end
endmodule

// File: rtl/vlcfg_dec.sv
module vlcfg_dec
  import vlcfg_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] A_MVL  = 12'h0C0,
  parameter logic [ADDR_W-1:0] A_VL   = 12'h0C1,
  parameter logic [ADDR_W-1:0] A_PACK = 12'h0C2
) (
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output wr_kind_e          kind_o,
  output logic              zero_wr_o
);
  logic len_addr;
  logic is_zero;

  assign len_addr = (wr_addr_i == A_MVL) || (wr_addr_i == A_VL);
  assign is_zero  = (wr_data_i == '0);

  always_comb begin
    kind_o    = WK_NONE;
    zero_wr_o = 1'b0;
    if (wr_en_i) begin
      if (len_addr && is_zero) begin
        zero_wr_o = 1'b1;
      end else if (wr_addr_i == A_MVL) begin
        kind_o = WK_MVL;
      end else if (wr_addr_i == A_VL) begin
        kind_o = WK_VL;
      end else if (wr_addr_i == A_PACK) begin
        kind_o = WK_PACK;
      end
    end
  end
endmodule

// File: rtl/vlcfg_next.sv
module vlcfg_next
  import vlcfg_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int MAX_LEN = 64,
  parameter int NUM_OFF = 2,
  localparam int FLD_W  = $clog2(MAX_LEN),
  localparam int CNT_W  = $clog2(MAX_LEN + 1)
) (
  input  wr_kind_e                        kind_i,
  input  logic [DATA_W-1:0]               wr_data_i,
  input  logic [CNT_W-1:0]                mvl_i,
  input  logic [CNT_W-1:0]                vl_i,
  input  logic [NUM_OFF-1:0][FLD_W-1:0]   offs_i,
  output logic [CNT_W-1:0]                mvl_o,
  output logic [CNT_W-1:0]                vl_o,
  output logic [NUM_OFF-1:0][FLD_W-1:0]   offs_o
);
  logic [FLD_W-1:0]  f_mvl, f_vl;
  logic [DATA_W-1:0] mvl_cand, vl_cand;
  logic [FLD_W-1:0]  off_lim;

  assign f_mvl = wr_data_i[FLD_W-1:0];
  assign f_vl  = wr_data_i[2*FLD_W-1:FLD_W];

  always_comb begin
    case (kind_i)
      WK_MVL:  mvl_cand = wr_data_i;
      WK_PACK: mvl_cand = DATA_W'({1'b0, f_mvl}) + DATA_W'(1);
      default: mvl_cand = DATA_W'(mvl_i);
    endcase
    case (kind_i)
      WK_VL:   vl_cand = wr_data_i;
      WK_PACK: vl_cand = DATA_W'({1'b0, f_vl}) + DATA_W'(1);
      default: vl_cand = DATA_W'(vl_i);
    endcase
  end

  vlcfg_clamp #(.IN_W(DATA_W), .OUT_W(CNT_W)) u_clamp_mvl (
    .val_i (mvl_cand),
    .lim_i (CNT_W'(MAX_LEN)),
    .res_o (mvl_o)
  );

  // current length bounded by the largest length of the same write
  vlcfg_clamp #(.IN_W(DATA_W), .OUT_W(CNT_W)) u_clamp_vl (
    .val_i (vl_cand),
    .lim_i (mvl_o),
    .res_o (vl_o)
  );

  assign off_lim = FLD_W'(vl_o - CNT_W'(1));

  for (genvar k = 0; k < NUM_OFF; k++) begin : g_off
    logic [FLD_W-1:0] cand;
    assign cand = (kind_i == WK_PACK) ? wr_data_i[(k+2)*FLD_W +: FLD_W] : offs_i[k];
    vlcfg_clamp #(.IN_W(FLD_W), .OUT_W(FLD_W)) u_clamp_off (
      .val_i (cand),
      .lim_i (off_lim),
      .res_o (offs_o[k])
    );
  end
endmodule

// File: rtl/vlcfg_rdmux.sv
module vlcfg_rdmux #(
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32,
  parameter int MAX_LEN = 64,
  parameter int NUM_OFF = 2,
  parameter logic [ADDR_W-1:0] A_MVL  = 12'h0C0,
  parameter logic [ADDR_W-1:0] A_VL   = 12'h0C1,
  parameter logic [ADDR_W-1:0] A_PACK = 12'h0C2,
  localparam int FLD_W  = $clog2(MAX_LEN),
  localparam int CNT_W  = $clog2(MAX_LEN + 1),
  localparam int PACK_W = (NUM_OFF + 2) * FLD_W
) (
  input  logic [ADDR_W-1:0]             rd_addr_i,
  input  logic [CNT_W-1:0]              mvl_i,
  input  logic [CNT_W-1:0]              vl_i,
  input  logic [NUM_OFF-1:0][FLD_W-1:0] offs_i,
  output logic [DATA_W-1:0]             rd_data_o
);
  logic [PACK_W-1:0] packed_w;

  assign packed_w = {offs_i, FLD_W'(vl_i - CNT_W'(1)), FLD_W'(mvl_i - CNT_W'(1))};

  always_comb begin
    if (rd_addr_i == A_MVL)       rd_data_o = DATA_W'(mvl_i);
    else if (rd_addr_i == A_VL)   rd_data_o = DATA_W'(vl_i);
    else if (rd_addr_i == A_PACK) rd_data_o = DATA_W'(packed_w);
    else                          rd_data_o = '0;
  end
endmodule

// File: rtl/vec_len_cfg.sv
module vec_len_cfg
  import vlcfg_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32,
  parameter int MAX_LEN = 64,
  parameter logic [ADDR_W-1:0] A_MVL  = 12'h0C0,
  parameter logic [ADDR_W-1:0] A_VL   = 12'h0C1,
  parameter logic [ADDR_W-1:0] A_PACK = 12'h0C2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              illegal_o
);
  localparam int NUM_OFF = 2;
  localparam int FLD_W   = $clog2(MAX_LEN);
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  wr_kind_e                      kind;
  logic                          zero_wr;
  logic [CNT_W-1:0]              mvl_q, vl_q, mvl_n, vl_n;
  logic [NUM_OFF-1:0][FLD_W-1:0] offs_q, offs_n;
  logic                          ill_q;

  vlcfg_dec #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .A_MVL(A_MVL), .A_VL(A_VL), .A_PACK(A_PACK)
  ) u_dec (
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .kind_o    (kind),
    .zero_wr_o (zero_wr)
  );

  vlcfg_next #(
    .DATA_W(DATA_W), .MAX_LEN(MAX_LEN), .NUM_OFF(NUM_OFF)
  ) u_next (
    .kind_i    (kind),
    .wr_data_i (wr_data_i),
    .mvl_i     (mvl_q),
    .vl_i      (vl_q),
    .offs_i    (offs_q),
    .mvl_o     (mvl_n),
    .vl_o      (vl_n),
    .offs_o    (offs_n)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mvl_q  <= CNT_W'(1);
      vl_q   <= CNT_W'(1);
      offs_q <= '0;
      ill_q  <= 1'b0;
    end else begin
      ill_q <= zero_wr;
      if (kind != WK_NONE) begin
        mvl_q  <= mvl_n;
        vl_q   <= vl_n;
        offs_q <= offs_n;
      end
    end
  end

  assign illegal_o = ill_q;

  vlcfg_rdmux #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAX_LEN(MAX_LEN), .NUM_OFF(NUM_OFF),
    .A_MVL(A_MVL), .A_VL(A_VL), .A_PACK(A_PACK)
  ) u_rdmux (
    .rd_addr_i (rd_addr_i),
    .mvl_i     (mvl_q),
    .vl_i      (vl_q),
    .offs_i    (offs_q),
    .rd_data_o (rd_data_o)
  );
endmodule

// File: rtl/vlcfg_chk.sv
module vlcfg_chk #(
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32,
  parameter int MAX_LEN = 64,
  parameter logic [ADDR_W-1:0] A_MVL  = 12'h0C0,
  parameter logic [ADDR_W-1:0] A_VL   = 12'h0C1,
  parameter logic [ADDR_W-1:0] A_PACK = 12'h0C2,
  localparam int FLD_W = $clog2(MAX_LEN),
  localparam int CNT_W = $clog2(MAX_LEN + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic [ADDR_W-1:0] rd_addr_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              illegal_o,
  input logic [CNT_W-1:0]  mvl_q,
  input logic [CNT_W-1:0]  vl_q,
  input logic [1:0][FLD_W-1:0] offs_q
);
  logic zero_len_wr;
  assign zero_len_wr = wr_en_i && (wr_data_i == '0) &&
                       ((wr_addr_i == A_MVL) || (wr_addr_i == A_VL));

  AST_MVL_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mvl_q >= CNT_W'(1)) && (mvl_q <= CNT_W'(MAX_LEN))); // R2

  AST_VL_LE_MVL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vl_q >= CNT_W'(1)) && (vl_q <= mvl_q)); // R9

  AST_OFF_BELOW_VL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (CNT_W'(offs_q[0]) < vl_q) && (CNT_W'(offs_q[1]) < vl_q)); // R6

  AST_ZERO_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_len_wr |=> illegal_o && $stable(mvl_q) && $stable(vl_q) && $stable(offs_q)); // R8

  AST_ILL_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> $past(zero_len_wr)); // R8

  AST_PACK_MVL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == A_PACK) |=>
      mvl_q == ({1'b0, $past(wr_data_i[FLD_W-1:0])} + CNT_W'(1))); // R5

  AST_RD_PLAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr_i == A_MVL) |-> rd_data_o == DATA_W'(mvl_q)); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(mvl_q) && $stable(vl_q) && $stable(offs_q)); // R10
endmodule

bind vec_len_cfg vlcfg_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAX_LEN(MAX_LEN),
  .A_MVL(A_MVL), .A_VL(A_VL), .A_PACK(A_PACK)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_addr_i (wr_addr_i),
  .wr_data_i (wr_data_i),
  .rd_addr_i (rd_addr_i),
  .rd_data_o (rd_data_o),
  .illegal_o (illegal_o),
  .mvl_q     (mvl_q),
  .vl_q      (vl_q),
  .offs_q    (offs_q)
);

// File: tb/vec_len_cfg_tb.sv
`timescale 1ns/1ps
module vec_len_cfg_tb;
  localparam logic [11:0] A_MVL  = 12'h0C0;
  localparam logic [11:0] A_VL   = 12'h0C1;
  localparam logic [11:0] A_PACK = 12'h0C2;
  localparam logic [11:0] A_NONE = 12'h0C3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [11:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [11:0] rd_addr = '0;
  logic [31:0] rd_data;
  logic        illegal;

  int n_chk = 0;
  int n_fail = 0;
  int m_mvl = 1, m_vl = 1, m_src = 0, m_dst = 0;
  bit m_ill = 0;

  always #2 clk = ~clk;

  vec_len_cfg u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data), .illegal_o(illegal)
  );

  function automatic int imin(int a, int b);
    return (a < b) ? a : b;
  endfunction

  function automatic logic [31:0] exp_pack();
    return 32'((m_mvl - 1) | ((m_vl - 1) << 6) | (m_src << 12) | (m_dst << 18));
  endfunction

  task automatic model(input logic [11:0] a, input logic [31:0] d);
    m_ill = 0;
    if ((a == A_MVL || a == A_VL) && d == 0) begin
      m_ill = 1;
    end else if (a == A_MVL) begin
      m_mvl = (d > 64) ? 64 : int'(d);
      m_vl  = imin(m_vl, m_mvl);
      m_src = imin(m_src, m_vl - 1);
      m_dst = imin(m_dst, m_vl - 1);
    end else if (a == A_VL) begin
      m_vl  = (d > 32'(m_mvl)) ? m_mvl : int'(d);
      m_src = imin(m_src, m_vl - 1);
      m_dst = imin(m_dst, m_vl - 1);
    end else if (a == A_PACK) begin
      m_mvl = int'(d[5:0]) + 1;
      m_vl  = imin(m_mvl, int'(d[11:6]) + 1);
      m_src = imin(int'(d[17:12]), m_vl - 1);
      m_dst = imin(int'(d[23:18]), m_vl - 1);
    end
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic read_all(input string tag);
    rd_addr = A_MVL;  #0.3; check({tag, " R7 largest length read"}, rd_data, 32'(m_mvl));
    rd_addr = A_VL;   #0.3; check({tag, " R7 current length read"}, rd_data, 32'(m_vl));
    rd_addr = A_PACK; #0.3; check({tag, " R4 packed read"}, rd_data, exp_pack());
    rd_addr = A_NONE; #0.3; check({tag, " R10 unmapped read"}, rd_data, 32'd0);
  endtask

  // drive at negedge, the write lands at the next posedge, sample at the following negedge
  task automatic wr(input string tag, input logic [11:0] a, input logic [31:0] d, input bit en = 1);
    @(negedge clk);
    wr_en = en; wr_addr = a; wr_data = d;
    if (en) model(a, d); else m_ill = 0;
    @(negedge clk);
    wr_en = 1'b0;
    check({tag, " R8 illegal flag"}, 32'(illegal), 32'(m_ill));
    read_all(tag);
  endtask

  initial begin
    #100000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1 illegal at reset", 32'(illegal), 32'd0);
    read_all("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);

    wr("R2 saturate", A_MVL, 32'd100);
    wr("R2 exact max", A_MVL, 32'd64);
    wr("R3 clamp to largest", A_VL, 32'd70);
    wr("R3 plain", A_VL, 32'd40);
    wr("R6 offsets set", A_PACK, {8'd0, 6'd30, 6'd25, 6'd39, 6'd63});
    wr("R9 shrink largest", A_MVL, 32'd5);
    wr("R8 zero largest", A_MVL, 32'd0);
    @(negedge clk);
    check("R8 flag single cycle", 32'(illegal), 32'd0);
    wr("R8 zero current", A_VL, 32'd0);
    wr("R5 chained clamp", A_PACK, {8'hFF, 6'd60, 6'd50, 6'd40, 6'd9});
    wr("R10 unmapped write", A_NONE, 32'h00FF_FFFF);
    wr("R10 strobe low", A_MVL, 32'd3, 0);
    wr("R5 full packed", A_PACK, {8'd0, 6'd63, 6'd62, 6'd63, 6'd63});
    wr("R9 current shrink", A_VL, 32'd2);

    for (int i = 0; i < 400; i++) begin
      int sel = int'($urandom_range(0, 3));
      logic [31:0] d;
      logic [11:0] a;
      case (sel)
        0: a = A_MVL;
        1: a = A_VL;
        2: a = A_PACK;
        default: a = A_NONE;
      endcase
      case ($urandom_range(0, 3))
        0: d = 32'($urandom_range(0, 3));
        1: d = 32'($urandom_range(0, 80));
        2: d = {8'd0, 6'($urandom), 6'($urandom), 6'($urandom_range(0, 12)), 6'($urandom_range(0, 12))};
        default: d = $urandom;
      endcase
      wr((sel == 0) ? "R2 random" : (sel == 1) ? "R3 random" : (sel == 2) ? "R6 random" : "R10 random", a, d);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule